// File: doc/BRIEF.md
# Timer Target Compare Unit

This block keeps a free-running 64-bit time counter and compares it every cycle with a 64-bit target value. When the two are equal, it produces a compare event. The event drives a one-cycle pulse on an output pin, sets a timer status bit and replaces the target with the next one.

The next target comes from one of two sources, selected by a mode bit. In reload mode the target is copied from a preloaded absolute 64-bit value, so software can place each next trigger time wherever it likes. In add mode a 32-bit increment is added to the current target, which gives a periodic event with no further software action. Both the counter and the target wrap modulo 2^64.

A 32-bit host write port reaches all registers. Each 64-bit register takes a new value only after both of its halves have been written, and the halves may arrive in either order. The status bit can be cleared in two ways: by the host, or by a qualified active level on an external clear pin. The status bit, gated by an enable, forms the interrupt output.

Top module: `target_match_timer`

## Requirements
- R1: During and after reset, the time counter starts at 0 and the target is all ones. The reload value is 0, the mode is add, the interrupt enable is off, the counter step is 1, and the status bit and all outputs are 0.
- R2: The time counter advances by the step value on every cycle in which no counter commit occurs. The step value is written at control address 6, bits [15:8].
- R3: A 64-bit register has its low half at an even address and its high half at the next odd address: counter at 0/1, target at 2/3, reload at 4/5. It changes only after both halves have been written, in either order, and the new value appears one cycle after the write of the second half. A single half write leaves the register unchanged.
- R4: When the counter equals the target, `matchPulse` is high for the next cycle and the status bit is set at that same edge.
- R5: With the mode bit set (control address 6, bit 0 = 1), a compare event loads the target from the full 64-bit reload value.
- R6: With the mode bit clear, a compare event adds the low 32 bits of the reload value to the target, modulo 2^64.
- R7: Writing the counter to a value equal to the current target produces a compare event.
- R8: `timerIrq` is the status bit gated by the enable at control address 6, bit 1.
- R9: Writing address 7 with bit 0 = 1 clears the status bit. A compare event at the same edge takes priority and the bit stays set.
- R10: The status bit is also cleared when `clearPin` is high for at least MIN_HIGH consecutive clock samples (default 9, more than 40 ns at 200 MHz). A shorter high pulse has no effect.
- R11: The counter passes from all ones to zero, and compare events keep working across that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 3 | Host register address |
| wrData | input | 32 | Host write data |
| clearPin | input | 1 | External status-clear input, active high |
| clockNow | output | 64 | Current time counter value |
| matchPulse | output | 1 | One-cycle compare event pulse |
| timerStatus | output | 1 | Timer status bit |
| timerIrq | output | 1 | Status bit gated by its enable |

## Verification
The hardest case to reach from the ports is a host clear of the status bit that falls on the same edge as a compare event. A clock-only timer never lines these up reliably. The bench gets there by committing the counter to a value equal to the target, so the event edge is known exactly: it is the edge after the commit. It then schedules the status-clear write for that edge. The input filter is tested at the threshold from both sides, with pulses one sample short of the limit and one sample past it.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  localparam int NUM_WIDE = 3;   // counter, target, reload
  localparam int IDX_CLOCK = 0;
  localparam int IDX_TARGET = 1;
  localparam int IDX_RELOAD = 2;

  typedef struct packed {
    logic [NUM_WIDE-1:0] grabLo;
    logic [NUM_WIDE-1:0] grabHi;
    logic [NUM_WIDE-1:0] commit;
  } strobe_t;
endpackage

// File: rtl/tmt_ctrl.sv
module tmt_ctrl
  import tmt_pkg::*;
#(
  parameter int STEP_W   = 8,
  parameter int MIN_HIGH = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [31:0]       wrData,
  input  logic              hit,
  input  logic              clearPin,
  output strobe_t           stb,
  output logic              modeReload,
  output logic [STEP_W-1:0] stepVal,
  output logic              statusBit,
  output logic              irqOut
);
  localparam int CNT_W = $clog2(MIN_HIGH + 1);
  localparam logic [2:0] ADDR_CTRL = 3'd6;
  localparam logic [2:0] ADDR_STAT = 3'd7;

  logic irqEn;
  logic [NUM_WIDE-1:0] flagLo, flagHi;

  // per-half written flags for each wide register
  for (genvar i = 0; i < NUM_WIDE; i++) begin : gHalf
    logic wLo, wHi;
    assign wLo = wrEn && (wrAddr == 3'(2 * i));
    assign wHi = wrEn && (wrAddr == 3'(2 * i + 1));
    assign stb.grabLo[i] = wLo;
    assign stb.grabHi[i] = wHi;
    assign stb.commit[i] = flagLo[i] && flagHi[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagLo[i] <= 1'b0;
        flagHi[i] <= 1'b0;
      end else begin
        flagLo[i] <= (flagLo[i] && !stb.commit[i]) || wLo;
        flagHi[i] <= (flagHi[i] && !stb.commit[i]) || wHi;
      end
    end

    // a commit without a fresh half write leaves no pending commit (R3)
    assert_commit_once_R3: assert property (@(posedge clk) disable iff (!rstN)
      (stb.commit[i] && !wLo && !wHi) |=> !stb.commit[i]);
  end

  // control register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReload <= 1'b0;
      irqEn      <= 1'b0;
      stepVal    <= STEP_W'(1);
    end else if (wrEn && wrAddr == ADDR_CTRL) begin
      modeReload <= wrData[0];
      irqEn      <= wrData[1];
      stepVal    <= wrData[8 +: STEP_W];
    end
  end

  // clear-pin filter: two-flop synchronizer then a run-length counter
  logic syncA, syncB;
  logic [CNT_W-1:0] runCnt;
  logic pinClear;
  assign pinClear = syncB && (runCnt == CNT_W'(MIN_HIGH - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA  <= 1'b0;
      syncB  <= 1'b0;
      runCnt <= '0;
    end else begin
      syncA <= clearPin;
      syncB <= syncA;
      if (!syncB)
        runCnt <= '0;
      else if (runCnt < CNT_W'(MIN_HIGH))
        runCnt <= runCnt + 1'b1;
    end
  end

  // status bit: a compare event wins over any clear
  logic hostClear;
  assign hostClear = wrEn && (wrAddr == ADDR_STAT) && wrData[0];

  always_ff @(posedge clk) begin
    if (!rstN)
      statusBit <= 1'b0;
    else if (hit)
      statusBit <= 1'b1;
    else if (hostClear || pinClear)
      statusBit <= 1'b0;
  end

  assign irqOut = statusBit && irqEn;

  assert_hit_sets_status_R4: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> statusBit);
  assert_host_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hostClear && !hit) |=> !statusBit);
  assert_fall_has_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusBit) |-> $past(hostClear || (syncB && runCnt != '0)));
endmodule

// File: rtl/tmt_datapath.sv
module tmt_datapath
  import tmt_pkg::*;
#(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [31:0]       wrData,
  input  logic              modeReload,
  input  logic [STEP_W-1:0] stepVal,
  output logic [63:0]       clockNow,
  output logic              hit,
  output logic              evtPulse
);
  logic [NUM_WIDE-1:0][63:0] holdReg;
  logic [63:0] clockQ, targetQ, reloadQ, nextTarget;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
    end else begin
      for (int i = 0; i < NUM_WIDE; i++) begin
        if (stb.grabLo[i]) holdReg[i][31:0]  <= wrData;
        if (stb.grabHi[i]) holdReg[i][63:32] <= wrData;
      end
    end
  end

  assign hit = (clockQ == targetQ);
  assign nextTarget = modeReload ? reloadQ : targetQ + {32'b0, reloadQ[31:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clockQ   <= '0;
      targetQ  <= '1;
      reloadQ  <= '0;
      evtPulse <= 1'b0;
    end else begin
      clockQ   <= stb.commit[IDX_CLOCK] ? holdReg[IDX_CLOCK]
                                        : clockQ + 64'(stepVal);
      if (stb.commit[IDX_TARGET])
        targetQ <= holdReg[IDX_TARGET];
      else if (hit)
        targetQ <= nextTarget;
      if (stb.commit[IDX_RELOAD])
        reloadQ <= holdReg[IDX_RELOAD];
      evtPulse <= hit;
    end
  end

  assign clockNow = clockQ;

  assert_target_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.commit[IDX_TARGET] && !hit) |=> $stable(targetQ));
  assert_reload_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hit && modeReload && !stb.commit[IDX_TARGET]) |=> targetQ == $past(reloadQ));
  assert_add_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !modeReload && !stb.commit[IDX_TARGET])
      |=> targetQ == $past(targetQ) + {32'b0, $past(reloadQ[31:0])});
  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit[IDX_CLOCK] |=> clockQ == $past(clockQ) + 64'($past(stepVal)));
endmodule

// File: rtl/target_match_timer.sv
module target_match_timer
  import tmt_pkg::*;
#(
  parameter int STEP_W   = 8,
  parameter int MIN_HIGH = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic        clearPin,
  output logic [63:0] clockNow,
  output logic        matchPulse,
  output logic        timerStatus,
  output logic        timerIrq
);
  strobe_t stb;
  logic hit, modeReload;
  logic [STEP_W-1:0] stepVal;

  tmt_ctrl #(.STEP_W(STEP_W), .MIN_HIGH(MIN_HIGH)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hit(hit), .clearPin(clearPin), .stb(stb), .modeReload(modeReload),
    .stepVal(stepVal), .statusBit(timerStatus), .irqOut(timerIrq)
  );

  tmt_datapath #(.STEP_W(STEP_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .modeReload(modeReload), .stepVal(stepVal), .clockNow(clockNow),
    .hit(hit), .evtPulse(matchPulse)
  );
endmodule

// File: tb/tb_target_match_timer.sv
`timescale 1ns/1ps
module tb_target_match_timer;
  localparam int MIN_HIGH = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic clearPin = 1'b0;
  logic [63:0] clockNow;
  logic matchPulse, timerStatus, timerIrq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  target_match_timer #(.STEP_W(8), .MIN_HIGH(MIN_HIGH)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .clearPin(clearPin), .clockNow(clockNow), .matchPulse(matchPulse),
    .timerStatus(timerStatus), .timerIrq(timerIrq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sampled at the next rising edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setCtrl(input logic mode, input logic en, input logic [7:0] step);
    wr(3'd6, {16'b0, step, 6'b0, en, mode});
  endtask

  task automatic setWide(input int base, input logic [63:0] v, input logic hiFirst);
    if (hiFirst) begin
      wr(3'(base + 1), v[63:32]); wr(3'(base), v[31:0]);
    end else begin
      wr(3'(base), v[31:0]); wr(3'(base + 1), v[63:32]);
    end
    @(negedge clk);  // commit edge
  endtask

  task automatic waitPulse(input int maxc, output logic found, output logic [63:0] val);
    found = 1'b0; val = '0;
    for (int i = 0; i < maxc && !found; i++) begin
      @(negedge clk);
      if (matchPulse) begin found = 1'b1; val = clockNow; end
    end
  endtask

  task automatic t_reset();
    check("R1 clock in reset", clockNow, 64'd0);
    check("R1 status", {63'b0, timerStatus}, 64'd0);
    check("R1 irq", {63'b0, timerIrq}, 64'd0);
    check("R1 pulse", {63'b0, matchPulse}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 default step", clockNow, 64'd1);
  endtask

  task automatic t_step();
    logic [63:0] c0;
    setCtrl(1'b0, 1'b0, 8'd3);
    c0 = clockNow;
    idle(2);
    check("R2 step three", clockNow, c0 + 64'd6);
    setCtrl(1'b0, 1'b0, 8'd1);
  endtask

  task automatic t_halves();
    logic [63:0] c0;
    wr(3'd0, 32'h0000_1234);
    c0 = clockNow;
    idle(3);
    check("R3 single half no effect", clockNow, c0 + 64'd3);
    wr(3'd1, 32'h0000_0005);
    @(negedge clk);
    check("R3 lo then hi", clockNow, 64'h0000_0005_0000_1234);
    setWide(0, 64'h0000_0007_0000_0100, 1'b1);
    check("R3 hi then lo", clockNow, 64'h0000_0007_0000_0100);
  endtask

  task automatic t_add();
    logic f; logic [63:0] v;
    setCtrl(1'b0, 1'b0, 8'd1);
    setWide(4, 64'h0000_0000_0000_0040, 1'b0);
    setWide(2, 64'h0000_0001_0000_0100, 1'b1);
    setWide(0, 64'h0000_0001_0000_00F0, 1'b0);
    wr(3'd7, 32'h1);
    check("R4 status cleared", {63'b0, timerStatus}, 64'd0);
    waitPulse(100, f, v);
    check("R4 first pulse", v, 64'h0000_0001_0000_0101);
    check("R4 status set", {63'b0, timerStatus}, 64'd1);
    @(negedge clk);
    check("R4 pulse one cycle", {63'b0, matchPulse}, 64'd0);
    waitPulse(100, f, v);
    check("R6 add increment", v, 64'h0000_0001_0000_0141);
  endtask

  task automatic t_reload();
    logic f; logic [63:0] v;
    setCtrl(1'b1, 1'b0, 8'd1);
    setWide(4, 64'h0000_0001_0000_0230, 1'b1);
    setWide(2, 64'h0000_0001_0000_0200, 1'b0);
    setWide(0, 64'h0000_0001_0000_01F8, 1'b1);
    waitPulse(100, f, v);
    check("R5 first reload pulse", v, 64'h0000_0001_0000_0201);
    waitPulse(100, f, v);
    check("R5 reloaded target", v, 64'h0000_0001_0000_0231);
  endtask

  task automatic t_wrap();
    logic f; logic [63:0] v;
    setCtrl(1'b0, 1'b0, 8'd1);
    setWide(4, 64'h0000_0000_0000_0020, 1'b0);
    setWide(2, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0);
    setWide(0, 64'hFFFF_FFFF_FFFF_FFE0, 1'b0);
    waitPulse(100, f, v);
    check("R11 pulse before wrap", v, 64'hFFFF_FFFF_FFFF_FFF1);
    waitPulse(100, f, v);
    check("R11 R6 pulse after wrap", v, 64'h0000_0000_0000_0011);
  endtask

  task automatic t_irq();
    check("R8 status held", {63'b0, timerStatus}, 64'd1);
    check("R8 masked", {63'b0, timerIrq}, 64'd0);
    setCtrl(1'b0, 1'b1, 8'd1);
    check("R8 enabled", {63'b0, timerIrq}, 64'd1);
    wr(3'd7, 32'h1);
    check("R9 host clear", {63'b0, timerStatus}, 64'd0);
    check("R8 irq follows", {63'b0, timerIrq}, 64'd0);
  endtask

  task automatic t_sameEdge();
    logic [63:0] tgt;
    tgt = 64'h5000_0000_0000_0000;
    setCtrl(1'b1, 1'b1, 8'd1);
    setWide(4, 64'd0, 1'b0);
    setWide(2, tgt, 1'b0);
    wr(3'd7, 32'h1);
    check("R7 status clear before", {63'b0, timerStatus}, 64'd0);
    wr(3'd0, tgt[31:0]);
    wr(3'd1, tgt[63:32]);
    @(negedge clk);                 // counter commit to the target value
    check("R7 counter equals target", clockNow, tgt);
    wr(3'd7, 32'h1);                // clear on the compare edge
    check("R7 event from counter write", {63'b0, matchPulse}, 64'd1);
    check("R9 event beats clear", {63'b0, timerStatus}, 64'd1);
  endtask

  task automatic t_pin();
    clearPin = 1'b1;
    idle(MIN_HIGH - 1);
    clearPin = 1'b0;
    idle(8);
    check("R10 short pulse ignored", {63'b0, timerStatus}, 64'd1);
    clearPin = 1'b1;
    idle(MIN_HIGH + 1);
    clearPin = 1'b0;
    idle(4);
    check("R10 long pulse clears", {63'b0, timerStatus}, 64'd0);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    t_step();
    t_halves();
    t_add();
    t_reload();
    t_wrap();
    t_irq();
    t_sameEdge();
    t_pin();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule